// File: doc/BRIEF.md
# Latency-Hiding Warp Issue Scheduler

This block sits beside the issue stage of a single SIMD core and chooses, every clock cycle, which resident warp sends its next instruction. Each warp slot keeps two flags: whether a warp occupies it and whether that warp is stalled behind a long-latency result, such as a memory load. A warp that starts such an operation is parked. It becomes eligible again when a completion pulse carrying its warp number comes back. Completions may return in any order.

Among the eligible warps, a rotating priority picks exactly one. The search starts one slot past the warp issued most recently, so every ready warp is served within one rotation. The grant is a combinational function of the registered slot state. A warp can therefore follow a different warp on the very next cycle with no dead cycle in between. Whenever at least one warp is ready, an issue happens in that cycle. Fetch, decode and execution are outside this block. The consumer of the grant always accepts it.

Top module: `warp_issue_sched`

## Requirements
- R1: A warp is ready when its slot is occupied and not stalled. `issue_valid` is high only when the slot named by `issue_warp` is ready, and at most one warp is granted per cycle.
- R2: A start pulse (`ll_start_valid`) for an occupied slot marks that warp stalled from the next cycle. The warp is not granted again until its completion arrives.
- R3: A completion pulse (`ll_done_valid`) naming a stalled warp clears the stall at the next clock edge. The warp may be granted in the cycle that follows the pulse.
- R4: If any warp is ready, `issue_valid` is 1 in that same cycle. If none is ready, `issue_valid` is 0.
- R5: The grant goes to the first ready slot found by searching upward from (last granted slot + 1), wrapping from slot NUM_SLOTS-1 to slot 0. After reset the search starts at slot 0. With all 8 slots ready continuously, consecutive grants step by one, modulo 8.
- R6: Warp numbers are 3 bits wide for the default 8 slots. Slot n is addressed by the binary value n on every warp-number port.
- R7: A start and a completion for the same occupied warp in the same cycle leave that warp stalled.
- R8: A retire clears the slot's occupied and stalled flags at the next edge, and a launch in the next cycle refills the slot as ready. A launch naming a slot that is already occupied has no effect, and a stalled warp stays stalled.
- R9: A completion naming a warp that is not stalled, and a start naming an empty slot, have no effect.
- R10: While `rst_n` is low, every slot is empty and `issue_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Place a new warp in slot `launch_warp` |
| launch_warp | input | ID_W | Slot to fill |
| retire_valid | input | 1 | Free slot `retire_warp` |
| retire_warp | input | ID_W | Slot to free |
| ll_start_valid | input | 1 | Warp `ll_start_warp` began a long-latency operation |
| ll_start_warp | input | ID_W | Warp that stalls |
| ll_done_valid | input | 1 | Long-latency result returned for `ll_done_warp` |
| ll_done_warp | input | ID_W | Warp whose result returned |
| issue_valid | output | 1 | A warp is granted issue this cycle |
| issue_warp | output | ID_W | Granted warp number |

## Verification
The bench targets the cases where an incorrect scheduler diverges quietly:
- A start and a completion for the same warp in one cycle: a design that lets the completion win would re-issue a warp whose data has not arrived.
- A launch aimed at a stalled, occupied slot: a design that does not ignore it would wrongly wake the warp, and the grant order would pick it up.
- Stray completions and starts aimed at idle or empty slots: a design that mishandles them would invent or lose warps.
- Completions that return out of launch order, and cycles where every warp is stalled: a design with a bubble, or one that grants an empty slot, shows a wrong `issue_valid`.
- A long run with all slots ready: a design that does not step the rotation by one slot per grant shows a wrong issue order.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
   // Selects the implementation of the rotating-priority search.
   typedef enum logic [0:0] {
      ARB_SCAN = 1'b0,   // linear search from the slot after the last grant
      ARB_MASK = 1'b1    // upper-half mask, then lowest-set-bit fallback
   } arb_impl_e;
endpackage

// File: rtl/wsched_slot.sv
module wsched_slot (
   input  logic clk,
   input  logic rst_n,
   input  logic launch_i,
   input  logic retire_i,
   input  logic start_i,
   input  logic done_i,
   output logic valid_o,
   output logic waiting_o
);
   logic valid_q, waiting_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q   <= 1'b0;
         waiting_q <= 1'b0;
      end else if (retire_i) begin
         valid_q   <= 1'b0;
         waiting_q <= 1'b0;
      end else if (!valid_q) begin
         // empty slot: only a launch matters, a start is ignored
         if (launch_i) begin
            valid_q   <= 1'b1;
            waiting_q <= 1'b0;
         end
      end else if (start_i) begin
         waiting_q <= 1'b1;               // start beats a same-cycle completion
      end else if (done_i) begin
         waiting_q <= 1'b0;
      end
   end

   assign valid_o   = valid_q;
   assign waiting_o = waiting_q;

   assert_retire_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
      retire_i |=> (!valid_q && !waiting_q));
   assert_start_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && start_i && done_i && !retire_i) |=> waiting_q);
   assert_done_wakes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && waiting_q && done_i && !start_i && !retire_i) |=> (valid_q && !waiting_q));
   assert_stall_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && start_i && !retire_i) |=> waiting_q);
   assert_relaunch_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && waiting_q && launch_i && !retire_i && !done_i) |=> waiting_q);
   assert_empty_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_q && start_i && !launch_i) |=> (!valid_q && !waiting_q));
endmodule

// File: rtl/wsched_rr_arb.sv
module wsched_rr_arb
   import wsched_pkg::*;
#(
   parameter int        N    = 8,
   parameter arb_impl_e IMPL = ARB_SCAN,
   localparam int       IW   = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] last_id,
   output logic          gnt_valid,
   output logic [IW-1:0] gnt_id
);
   // slot that heads the search this cycle
   logic [IW-1:0] head;
   assign head = (int'(last_id) == N - 1) ? '0 : IW'(int'(last_id) + 1);

   assign gnt_valid = |req;

   generate
      if (IMPL == ARB_SCAN) begin : g_scan
         always_comb begin
            logic found;
            found  = 1'b0;
            gnt_id = '0;
            for (int i = 0; i < N; i++) begin
               int idx;
               idx = (int'(last_id) + 1 + i) % N;
               if (!found && req[idx]) begin
                  found  = 1'b1;
                  gnt_id = IW'(idx);
               end
            end
         end
      end else begin : g_mask
         logic [N-1:0] upper;
         always_comb begin
            for (int j = 0; j < N; j++) upper[j] = req[j] && (j > int'(last_id));
         end
         always_comb begin
            gnt_id = '0;
            if (|upper) begin
               for (int j = N - 1; j >= 0; j--) if (upper[j]) gnt_id = IW'(j);
            end else begin
               for (int j = N - 1; j >= 0; j--) if (req[j]) gnt_id = IW'(j);
            end
         end
      end
   endgenerate

   assert_grant_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |-> req[gnt_id]);
   assert_no_bubble_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0) |-> gnt_valid);
   assert_head_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req[head] |-> (gnt_id == head));
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
   import wsched_pkg::*;
#(
   parameter int        NUM_SLOTS = 8,
   parameter arb_impl_e ARB_IMPL  = ARB_SCAN,
   localparam int       ID_W      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            launch_valid,
   input  logic [ID_W-1:0] launch_warp,
   input  logic            retire_valid,
   input  logic [ID_W-1:0] retire_warp,
   input  logic            ll_start_valid,
   input  logic [ID_W-1:0] ll_start_warp,
   input  logic            ll_done_valid,
   input  logic [ID_W-1:0] ll_done_warp,
   output logic            issue_valid,
   output logic [ID_W-1:0] issue_warp
);
   if (NUM_SLOTS < 2) begin : g_bad_slots
      $error("warp_issue_sched: NUM_SLOTS must be at least 2");
   end

   logic [NUM_SLOTS-1:0] slot_valid, slot_wait, slot_ready;
   logic [ID_W-1:0]      last_q;

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      wsched_slot u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .launch_i (launch_valid   && (launch_warp   == ID_W'(g))),
         .retire_i (retire_valid   && (retire_warp   == ID_W'(g))),
         .start_i  (ll_start_valid && (ll_start_warp == ID_W'(g))),
         .done_i   (ll_done_valid  && (ll_done_warp  == ID_W'(g))),
         .valid_o  (slot_valid[g]),
         .waiting_o(slot_wait[g])
      );
   end

   assign slot_ready = slot_valid & ~slot_wait;

   wsched_rr_arb #(.N(NUM_SLOTS), .IMPL(ARB_IMPL)) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (slot_ready),
      .last_id  (last_q),
      .gnt_valid(issue_valid),
      .gnt_id   (issue_warp)
   );

   // last granted slot; reset value makes the first search start at slot 0
   always_ff @(posedge clk) begin
      if (!rst_n)           last_q <= ID_W'(NUM_SLOTS - 1);
      else if (issue_valid) last_q <= issue_warp;
   end

   assert_reset_idle_R10: assert property (@(posedge clk)
      $past(!rst_n) |-> (slot_valid == '0 && !issue_valid));
   assert_stalled_not_issued_R2: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> !slot_wait[issue_warp]);
endmodule

// File: tb/sim_warp_issue_sched.sv
module sim_warp_issue_sched;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       launch_valid = 1'b0, retire_valid = 1'b0, ll_start_valid = 1'b0, ll_done_valid = 1'b0;
   logic [2:0] launch_warp = '0, retire_warp = '0, ll_start_warp = '0, ll_done_warp = '0;
   logic       issue_valid;
   logic [2:0] issue_warp;
   int checks = 0, failures = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   warp_issue_sched u0 (
      .clk(clk), .rst_n(rst_n),
      .launch_valid(launch_valid), .launch_warp(launch_warp),
      .retire_valid(retire_valid), .retire_warp(retire_warp),
      .ll_start_valid(ll_start_valid), .ll_start_warp(ll_start_warp),
      .ll_done_valid(ll_done_valid), .ll_done_warp(ll_done_warp),
      .issue_valid(issue_valid), .issue_warp(issue_warp)
   );

   // {launch v,id | retire v,id | start v,id | done v,id | expected issue v,id}
   localparam int NV = 23;
   localparam logic [19:0] TBL [NV] = '{
      {1'b1,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0}, // 0  R4 nothing ready
      {1'b1,3'd2, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd0}, // 1  R5 first search from 0
      {1'b1,3'd5, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd2}, // 2  R5
      {1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd5}, // 3  R5
      {1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd0, 1'b0,3'd0, 1'b1,3'd0}, // 4  R5 wrap
      {1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd2}, // 5  R2 warp 0 skipped
      {1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd2, 1'b0,3'd0, 1'b1,3'd5}, // 6  R1
      {1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd5, 1'b0,3'd0, 1'b1,3'd5}, // 7  R2 only 5 ready
      {1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0}, // 8  R4 all stalled
      {1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd2, 1'b0,3'd0}, // 9  R3 out-of-order done
      {1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd0, 1'b1,3'd2}, // 10 R3 woken next cycle
      {1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd2, 1'b1,3'd2, 1'b1,3'd0}, // 11 R7 start+done same warp
      {1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd6, 1'b1,3'd7, 1'b1,3'd0}, // 12 R7 2 stays stalled; R9 stray
      {1'b0,3'd0, 1'b1,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd0}, // 13 R8 retire 0
      {1'b1,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0}, // 14 R8 slot freed
      {1'b1,3'd6, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd0}, // 15 R8 refilled; R9 6 empty
      {1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd5, 1'b1,3'd6}, // 16 R5
      {1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd0}, // 17 R5 wrap
      {1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd0, 1'b0,3'd0, 1'b1,3'd5}, // 18 R5 skips stalled 2
      {1'b1,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd6}, // 19 R8 launch on busy slot
      {1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd5}, // 20 R8 warp 0 still stalled
      {1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd2, 1'b1,3'd6}, // 21 R3
      {1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd2}  // 22 R3 R6 slot 2 granted
   };

   task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp_v);
      checks++;
      if (act !== exp_v) begin
         failures++;
         $display("FAIL %s actual valid=%0b warp=%0d expected valid=%0b warp=%0d",
                  tag, act[3], act[2:0], exp_v[3], exp_v[2:0]);
      end
   endtask

   task automatic idle_inputs();
      launch_valid = 1'b0; retire_valid = 1'b0; ll_start_valid = 1'b0; ll_done_valid = 1'b0;
   endtask

   initial begin
      logic [2:0] prev;
      repeat (3) @(negedge clk);
      #1 check("R10 in reset", {issue_valid, 3'd0}, 4'b0000);
      @(negedge clk); rst_n = 1'b1;
      // table walk: inputs set at negedge, outputs reflect state since last posedge
      for (int i = 0; i < NV; i++) begin
         if (i != 0) @(negedge clk);
         {launch_valid, launch_warp, retire_valid, retire_warp,
          ll_start_valid, ll_start_warp, ll_done_valid, ll_done_warp} = TBL[i][19:4];
         #1;
         if (TBL[i][3])
            check($sformatf("R1 R4 R5 row %0d", i), {issue_valid, issue_warp}, TBL[i][3:0]);
         else
            check($sformatf("R4 row %0d", i), {issue_valid, 3'd0}, 4'b0000);
      end
      // mid-run reset
      @(negedge clk); idle_inputs(); rst_n = 1'b0;
      @(negedge clk); #1 check("R10 reset clears", {issue_valid, 3'd0}, 4'b0000);
      rst_n = 1'b1;
      // fill every slot
      for (int s = 0; s < 8; s++) begin
         @(negedge clk); launch_valid = 1'b1; launch_warp = 3'(s);
      end
      @(negedge clk); idle_inputs(); #1 prev = issue_warp;
      check("R4 all ready", {issue_valid, 3'd0}, 4'b1000);
      // rotation with all ready; a stray completion to ready warp 3 changes nothing
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         ll_done_valid = (k == 4); ll_done_warp = 3'd3;
         #1 check("R5 R9 rotation", {issue_valid, issue_warp}, {1'b1, 3'(prev + 3'd1)});
         prev = issue_warp;
      end
      @(negedge clk); idle_inputs();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL R4 watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule